// File: doc/BRIEF.md
# Pairwise Widening Add Unit

This block executes the pairwise add-long vector family on a 128-bit operand. Each pair of adjacent narrow lanes in the source vector is widened (sign- or zero-extended), summed, and written into one result lane of double width. An optional accumulate form adds that sum to the matching lane of the current destination vector. A 64-bit form reads only the low half of the source and clears the upper half of the result.

The issuing stage presents a 32-bit instruction word together with the source and destination vector values and a valid strobe. One cycle later the unit returns either the result with a valid flag or an illegal-encoding flag. Register-file access, hazard tracking and all other instructions belong to the surrounding pipeline.

Top module: `pairadd_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid` and `out_illegal` go to 0 and `out_result` goes to all zeros.
- R2: The size field is instruction bits 23:22. Values 0, 1 and 2 select source lanes of 8, 16 and 32 bits. Result lane e is twice the source lane width and is the sum of source lanes 2e and 2e+1, truncated to the result lane width.
- R3: Instruction bit 29 selects the extension. A value of 1 zero-extends both source lanes. A value of 0 sign-extends them, so all-ones lanes sum to -2 and most-negative lanes sum to twice the most negative value.
- R4: Instruction bit 14 set (accumulate form) adds destination lane e to the pair sum, wrapping at the result lane width. When bit 14 is clear, the destination vector has no effect on the result.
- R5: Instruction bit 30 clear selects the 64-bit form. Only source bits 63:0 are used, and result bits 127:64 are zero, even in the accumulate form. Bit 30 set uses all 128 bits.
- R6: A size field of 3 is reserved. It produces `out_illegal`=1 and `out_valid`=0.
- R7: An instruction word is accepted only when bit 31 is 0, bits 28:24 are 01110, bits 21:16 are 100000, bit 15 is 0 and bits 13:10 are 1010. Any other word gives `out_illegal`=1 and `out_valid`=0.
- R8: An accepted strobe raises `out_valid` exactly one cycle later. A rejected strobe raises `out_illegal` one cycle later. Both flags are 0 in a cycle that follows no strobe.
- R9: `out_result` keeps its value in any cycle that does not follow an accepted strobe.
- R10: The register index fields (bits 9:5 and 4:0) have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| instr | input | 32 | Instruction word |
| src_vec | input | 128 | Source vector value |
| dst_vec | input | 128 | Current destination vector value |
| out_valid | output | 1 | Result valid, one cycle after an accepted strobe |
| out_result | output | 128 | Registered result vector |
| out_illegal | output | 1 | Rejected encoding, one cycle after the strobe |

## Verification
The unit has only one register stage, so any fault shows at the ports in the cycle right after the strobe. A wrong decoded size or signedness changes the lane boundaries or the upper bits of every lane. That difference is clearest with all-ones and most-negative operands. A missing upper-half clear leaves nonzero bits above bit 63 in the 64-bit form. A wrong hold enable lets the result change after a rejected or idle cycle, and this is visible at the next sample.

// File: rtl/pairadd_pkg.sv
// Shared constants and the decoded-operation type for the pairwise widening
// add unit. Assumes a vector width of 128 bits with a 64-bit short form.
package pairadd_pkg;

    // Number of legal source lane sizes (8, 16 and 32 bits).
    localparam int NUM_SIZES = 3;

    // Fixed opcode fields that every accepted word must carry.
    localparam logic [4:0] MATCH_28_24 = 5'b01110;
    localparam logic [5:0] MATCH_21_16 = 6'b100000;
    localparam logic [3:0] MATCH_13_10 = 4'b1010;

    // Decoded operation.
    typedef struct packed {
        logic       full;      // 1: 128-bit form, 0: 64-bit form
        logic       uns;       // 1: zero-extend lanes, 0: sign-extend
        logic       acc;       // 1: accumulate into destination lanes
        logic [1:0] size;      // source lane size code
        logic       legal;     // word is an accepted encoding
    } pa_op_t;

endpackage

// File: rtl/pairadd_decode.sv
// Instruction decoder for the pairwise widening add unit.
// Extracts the form, signedness, accumulate and size fields and checks the
// fixed opcode bits. Assumes the register index fields are resolved upstream,
// so they are not used here.
module pairadd_decode
    import pairadd_pkg::*;
(
    input  logic [31:0] instr,
    output pa_op_t      op
);

    logic pattern_ok;
    logic unused_reg_fields;

    // Compare the fixed opcode bits against the accepted pattern.
    always_comb begin
        pattern_ok = (instr[31] == 1'b0)
                  && (instr[28:24] == MATCH_28_24)
                  && (instr[21:16] == MATCH_21_16)
                  && (instr[15] == 1'b0)
                  && (instr[13:10] == MATCH_13_10);
    end

    // Unpack the variable fields and combine them into the legality flag.
    always_comb begin
        op.full  = instr[30];
        op.uns   = instr[29];
        op.acc   = instr[14];
        op.size  = instr[23:22];
        op.legal = pattern_ok && (instr[23:22] != 2'b11);
    end

    // Register index fields are consumed by the register file, not here.
    assign unused_reg_fields = ^instr[9:0];

endmodule

// File: rtl/pairadd_lane_engine.sv
// One fixed-size pairwise widening adder across the whole vector.
// For each result lane it extends two adjacent source lanes of ESZ bits to
// 2*ESZ bits, adds them, and adds the destination lane when accumulating.
// Assumes VEC_W is a multiple of 2*ESZ.
module pairadd_lane_engine #(
    parameter int VEC_W = 128,
    parameter int ESZ   = 8
) (
    input  logic [VEC_W-1:0] src,
    input  logic [VEC_W-1:0] dst,
    input  logic             is_unsigned,
    input  logic             do_acc,
    output logic [VEC_W-1:0] res
);

    localparam int WSZ   = 2 * ESZ;
    localparam int LANES = VEC_W / WSZ;

    for (genvar e = 0; e < LANES; e++) begin : g_lane
        logic [ESZ-1:0] lo_n;
        logic [ESZ-1:0] hi_n;
        logic [WSZ-1:0] lo_w;
        logic [WSZ-1:0] hi_w;
        logic [WSZ-1:0] acc_w;

        // Pick the two adjacent narrow lanes that feed this result lane.
        assign lo_n = src[(2*e)*ESZ +: ESZ];
        assign hi_n = src[(2*e+1)*ESZ +: ESZ];

        // Widen each narrow lane by its sign bit or by zeros.
        assign lo_w = {{ESZ{lo_n[ESZ-1] & ~is_unsigned}}, lo_n};
        assign hi_w = {{ESZ{hi_n[ESZ-1] & ~is_unsigned}}, hi_n};

        // Destination lane joins the sum only in the accumulate form.
        assign acc_w = do_acc ? dst[e*WSZ +: WSZ] : '0;

        // Wrapping sum at the result lane width.
        assign res[e*WSZ +: WSZ] = lo_w + hi_w + acc_w;
    end

endmodule

// File: rtl/pairadd_unit.sv
// Top of the pairwise widening add unit.
// Decodes the instruction word and runs one lane engine per legal lane size
// in parallel, then selects by size and clears the upper half in the 64-bit
// form. Results and flags are registered one cycle after the strobe. The
// result register holds its value unless an accepted operation completes.
module pairadd_unit
    import pairadd_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [31:0]      instr,
    input  logic [VEC_W-1:0] src_vec,
    input  logic [VEC_W-1:0] dst_vec,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_result,
    output logic             out_illegal
);

    localparam int HALF = VEC_W / 2;

    pa_op_t                             op;
    logic [VEC_W-1:0]                   src_eff;
    logic [NUM_SIZES-1:0][VEC_W-1:0]    eng_res;
    logic [VEC_W-1:0]                   sel_res;
    logic [VEC_W-1:0]                   next_res;
    logic                               accept;

    pairadd_decode u_decode (
        .instr (instr),
        .op    (op)
    );

    // Short form only sees the low half of the source.
    always_comb begin
        src_eff = op.full ? src_vec : {{HALF{1'b0}}, src_vec[HALF-1:0]};
    end

    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
        pairadd_lane_engine #(
            .VEC_W (VEC_W),
            .ESZ   (8 << s)
        ) u_engine (
            .src         (src_eff),
            .dst         (dst_vec),
            .is_unsigned (op.uns),
            .do_acc      (op.acc),
            .res         (eng_res[s])
        );
    end

    // Select the engine that matches the decoded lane size.
    always_comb begin
        sel_res = '0;
        for (int s = 0; s < NUM_SIZES; s++) begin
            if (op.size == 2'(s)) begin
                sel_res = eng_res[s];
            end
        end
    end

    // Clear the upper half of the result in the short form.
    always_comb begin
        next_res = op.full ? sel_res : {{HALF{1'b0}}, sel_res[HALF-1:0]};
        accept   = in_valid && op.legal;
    end

    // Status flags: one-cycle response to each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_illegal <= 1'b0;
        end else begin
            out_valid   <= accept;
            out_illegal <= in_valid && !op.legal;
        end
    end

    // Result register: load on an accepted strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_result <= '0;
        end else if (accept) begin
            out_result <= next_res;
        end
    end

endmodule

// File: rtl/pairadd_checker.sv
// Protocol and datapath properties of the pairwise widening add unit,
// attached to every instance of the top module by the bind at the end.
module pairadd_checker #(
    parameter int VEC_W = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [31:0]      instr,
    input logic             out_valid,
    input logic [VEC_W-1:0] out_result,
    input logic             out_illegal
);

    localparam int HALF = VEC_W / 2;

    // R8: every strobe gets exactly one kind of response next cycle.
    p_one_response_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_valid ^ out_illegal));

    // R8: no response without a strobe.
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_illegal));

    // R6: reserved size is always rejected.
    p_reserved_size_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[23:22] == 2'b11) |=> (out_illegal && !out_valid));

    // R7: a set top bit never yields a valid result.
    p_bad_top_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[31]) |=> out_illegal);

    // R9: result holds across an idle cycle.
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_result));

    // R9: result holds across a rejected strobe.
    p_hold_illegal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> $stable(out_result));

    // R5: short form leaves the upper half zero.
    p_short_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !instr[30]) |=> (!out_valid || out_result[VEC_W-1:HALF] == '0));

endmodule

bind pairadd_unit pairadd_checker #(.VEC_W(VEC_W)) i_pairadd_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .instr       (instr),
    .out_valid   (out_valid),
    .out_result  (out_result),
    .out_illegal (out_illegal)
);

// File: tb/test_pairadd_unit.sv
// Directed bench for the pairwise widening add unit: one task per scenario,
// expected values from a per-lane behavioural model.
module test_pairadd_unit;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [31:0]  instr = '0;
    logic [127:0] src_vec = '0;
    logic [127:0] dst_vec = '0;
    logic         out_valid;
    logic [127:0] out_result;
    logic         out_illegal;

    int checks = 0;
    int errors = 0;
    logic [127:0] last_res = '0;

    always #4 clk = ~clk;

    pairadd_unit i_pairadd_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .src_vec(src_vec), .dst_vec(dst_vec), .out_valid(out_valid),
        .out_result(out_result), .out_illegal(out_illegal)
    );

    // Build an accepted instruction word from its fields.
    function automatic logic [31:0] mk(input logic q, input logic u, input logic acc,
                                       input logic [1:0] sz, input logic [4:0] rn,
                                       input logic [4:0] rd);
        return {1'b0, q, u, 5'b01110, sz, 6'b100000, 1'b0, acc, 4'b1010, rn, rd};
    endfunction

    // Per-lane behavioural model.
    function automatic logic [127:0] model(input logic q, input logic u, input logic acc,
                                           input logic [1:0] sz, input logic [127:0] s,
                                           input logic [127:0] d);
        int esz = 8 << sz;
        int n = (q ? 128 : 64) / (2 * esz);
        logic [127:0] r = '0;
        logic [63:0] nmask = (64'd1 << esz) - 64'd1;
        logic [63:0] wmask = (esz == 32) ? '1 : ((64'd1 << (2 * esz)) - 64'd1);
        for (int e = 0; e < n; e++) begin
            logic [63:0] a = 64'(s >> (2 * e * esz)) & nmask;
            logic [63:0] b = 64'(s >> ((2 * e + 1) * esz)) & nmask;
            logic [63:0] sum;
            if (!u && a[esz-1]) a = a | ~nmask;
            if (!u && b[esz-1]) b = b | ~nmask;
            sum = a + b;
            if (acc) sum = sum + (64'(d >> (e * 2 * esz)) & wmask);
            r = r | (128'(sum & wmask) << (e * 2 * esz));
        end
        return r;
    endfunction

    task automatic chk128(input string tag, input logic [127:0] got, input logic [127:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic chk1(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %b expected %b", tag, got, exp);
        end
    endtask

    // Present one strobe; returns after the response has been registered.
    task automatic apply(input logic [31:0] w, input logic [127:0] s, input logic [127:0] d);
        @(negedge clk);
        in_valid = 1'b1; instr = w; src_vec = s; dst_vec = d;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Run one legal operation and compare against the model.
    task automatic run_legal(input string tag, input logic q, input logic u, input logic acc,
                             input logic [1:0] sz, input logic [127:0] s, input logic [127:0] d);
        logic [127:0] exp = model(q, u, acc, sz, s, d);
        apply(mk(q, u, acc, sz, 5'd1, 5'd0), s, d);
        chk1({tag, " valid"}, out_valid, 1'b1);
        chk128(tag, out_result, exp);
        last_res = exp;
    endtask

    task automatic t_reset;
        chk1("R1 valid after reset", out_valid, 1'b0);
        chk1("R1 illegal after reset", out_illegal, 1'b0);
        chk128("R1 result after reset", out_result, '0);
    endtask

    task automatic t_sizes;
        logic [127:0] pat = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
        for (int sz = 0; sz < 3; sz++) begin
            run_legal("R2 pattern signed", 1'b1, 1'b0, 1'b0, 2'(sz), pat, '0);
            run_legal("R2 pattern unsigned", 1'b1, 1'b1, 1'b0, 2'(sz), pat, '0);
        end
    endtask

    task automatic t_signedness;
        logic [127:0] neg8 = {16{8'h80}};
        run_legal("R3 all ones signed 8", 1'b1, 1'b0, 1'b0, 2'd0, '1, '0);
        chk128("R3 all ones signed 8 lanes -2", out_result, {8{16'hFFFE}});
        run_legal("R3 all ones unsigned 8", 1'b1, 1'b1, 1'b0, 2'd0, '1, '0);
        chk128("R3 all ones unsigned 8 lanes 0x1FE", out_result, {8{16'h01FE}});
        run_legal("R3 most negative 8", 1'b1, 1'b0, 1'b0, 2'd0, neg8, '0);
        chk128("R3 most negative 8 lanes -256", out_result, {8{16'hFF00}});
        run_legal("R3 most negative 32", 1'b1, 1'b0, 1'b0, 2'd2, {4{32'h8000_0000}}, '0);
        run_legal("R3 all ones unsigned 32", 1'b1, 1'b1, 1'b0, 2'd2, '1, '0);
    endtask

    task automatic t_accumulate;
        run_legal("R4 wrap unsigned 8", 1'b1, 1'b1, 1'b1, 2'd0, '1, '1);
        chk128("R4 wrap lanes 0x01FD", out_result, {8{16'h01FD}});
        run_legal("R4 signed 16", 1'b1, 1'b0, 1'b1, 2'd1,
                  128'h8000_7FFF_FFFF_0001_1234_ABCD_0000_FFFF,
                  128'h0000_0001_FFFF_FFFF_8000_0000_7FFF_FFFF);
        run_legal("R4 signed 32", 1'b1, 1'b0, 1'b1, 2'd2, {4{32'h8000_0000}}, '1);
        run_legal("R4 plain ignores dst", 1'b1, 1'b1, 1'b0, 2'd1, {8{16'h0102}}, '1);
        chk128("R4 plain ignores dst value", out_result, {4{32'h0000_0204}});
    endtask

    task automatic t_short_form;
        run_legal("R5 short acc 8", 1'b0, 1'b1, 1'b1, 2'd0, '1, '1);
        chk128("R5 upper half zero", {out_result[127:64], 64'h0}, '0);
        run_legal("R5 short signed 32", 1'b0, 1'b0, 1'b0, 2'd2,
                  128'hAAAA_AAAA_AAAA_AAAA_8000_0000_FFFF_FFFF, '0);
        run_legal("R5 full 32 acc", 1'b1, 1'b0, 1'b1, 2'd2,
                  128'hAAAA_AAAA_AAAA_AAAA_8000_0000_FFFF_FFFF, {4{32'h1}});
    endtask

    task automatic t_reserved;
        logic [31:0] w = mk(1'b1, 1'b1, 1'b0, 2'd3, 5'd0, 5'd0);
        apply(w, '1, '1);
        chk1("R6 illegal flag", out_illegal, 1'b1);
        chk1("R6 no valid", out_valid, 1'b0);
        chk128("R9 result held after reserved size", out_result, last_res);
    endtask

    task automatic t_bad_pattern;
        logic [31:0] base = mk(1'b1, 1'b0, 1'b1, 2'd1, 5'd2, 5'd3);
        apply(base | 32'h8000_0000, '1, '1);
        chk1("R7 bit31 illegal", out_illegal, 1'b1);
        chk1("R7 bit31 no valid", out_valid, 1'b0);
        apply(base ^ 32'h0000_1000, '1, '1);
        chk1("R7 bit12 illegal", out_illegal, 1'b1);
        apply(base ^ 32'h0001_0000, '1, '1);
        chk1("R7 bit16 illegal", out_illegal, 1'b1);
        apply(base ^ 32'h0000_8000, '1, '1);
        chk1("R7 bit15 illegal", out_illegal, 1'b1);
        chk128("R9 result held after bad pattern", out_result, last_res);
    endtask

    task automatic t_latency_idle;
        apply(mk(1'b1, 1'b0, 1'b0, 2'd0, 5'd0, 5'd0), {16{8'h05}}, '0);
        last_res = {8{16'h000A}};
        chk1("R8 valid one cycle after strobe", out_valid, 1'b1);
        chk1("R8 no illegal on accepted strobe", out_illegal, 1'b0);
        src_vec = '1;
        @(negedge clk);
        chk1("R8 valid drops when idle", out_valid, 1'b0);
        chk1("R8 illegal low when idle", out_illegal, 1'b0);
        chk128("R9 result held when idle", out_result, last_res);
    endtask

    task automatic t_reg_fields;
        logic [127:0] s = 128'hDEAD_BEEF_0BAD_F00D_1357_9BDF_2468_ACE0;
        logic [127:0] exp = model(1'b1, 1'b0, 1'b1, 2'd0, s, {8{16'h0101}});
        apply(mk(1'b1, 1'b0, 1'b1, 2'd0, 5'd31, 5'd17), s, {8{16'h0101}});
        chk128("R10 index fields ignored a", out_result, exp);
        apply(mk(1'b1, 1'b0, 1'b1, 2'd0, 5'd6, 5'd29), s, {8{16'h0101}});
        chk128("R10 index fields ignored b", out_result, exp);
        last_res = exp;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_sizes();
        t_signedness();
        t_accumulate();
        t_short_form();
        t_reserved();
        t_bad_pattern();
        t_latency_idle();
        t_reg_fields();
        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired got running expected finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule